// File: doc/BRIEF.md
# Pin Stream Micro-Instruction Interpreter

This block sits on the device side of a byte-coded pin-control channel. Bytes arrive on an upstream stream grouped into packets, with a flag on each packet's final byte. A packet opened by the header byte 0xAB is interpreted one byte at a time as a small instruction. The two top bits of an instruction choose the operation and the six low bits carry a pin value, an enable mask or a microsecond count. Any other packet is swallowed whole.

The instructions drive a six-bit output register and a six-bit output-enable register, take timed pauses, and capture the eight pin input levels into a response byte stream. Every output load occupies a fixed step time, so that repeating one load back to back acts as a short fine-grained delay, as used when pulsing a chip select. An end instruction stops interpretation for the rest of the current packet. The block throttles the upstream with a ready signal while a timed step is in progress.

Top module: `pstream_interp`

## Requirements
- R1: After reset the output register holds 0x37 (chip select bit 0 high, clock bit 3 low, data bits high), every output enable is off (0x00), `up_ready` is high and `rsp_valid` is low.
- R2: A packet whose first byte is not 0xAB is consumed up to its last byte with no change to outputs, enables or responses.
- R3: Inside an open packet, a byte of the form 0x80|v (bits 7:6 = 10) loads the output register with v, visible on the cycle after the byte is accepted.
- R4: A byte of the form 0x40|m (bits 7:6 = 01) loads the output-enable register with m; 0x3F enables all pins and 0x00 tri-states all of them.
- R5: An output load occupies STEP_CYCLES clock cycles: `up_ready` stays low for STEP_CYCLES-1 cycles after it is accepted.
- R6: A byte of the form 0xC0|n (bits 7:6 = 11) holds `up_ready` low for n*CLK_PER_US-1 cycles after acceptance; n = 0 causes no stall.
- R7: A byte in 0x00..0x1F (bits 7:5 = 000) produces exactly one response byte carrying all eight `pin_in` levels as sampled on the accepting edge, with `rsp_valid` high on the following cycle for one cycle.
- R8: A byte in 0x20..0x3F (bits 7:5 = 001) ends interpretation; the remaining bytes of the packet are accepted without stall and have no effect.
- R9: The byte flagged last always closes the packet, so the next packet needs its own 0xAB header; a header that is itself the last byte does nothing.
- R10: The output register is loaded regardless of the enable state, so values written while tri-stated are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream byte present |
| up_data | input | 8 | Upstream byte |
| up_last | input | 1 | Byte closes the packet |
| up_ready | output | 1 | Block can accept a byte this cycle |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 6 | Output register |
| pin_oe | output | 6 | Output-enable register |
| rsp_valid | output | 1 | Response byte present (one-cycle pulse) |
| rsp_data | output | 8 | Response byte |

## Verification
The properties take for granted that the upstream byte, its last flag and the pin inputs are known values from reset release onward, and that `pin_in` is meaningful on the edge where a sample instruction is accepted; the stall properties are only built when the step and microsecond settings exceed one cycle. The stimulus changes every input on the falling edge only, holds a byte until the rising edge where `up_ready` is seen high, and alters `pin_in` only between bytes, so each sampled value is settled when captured.

// File: rtl/pstream_pkg.sv
package pstream_pkg;

  localparam int FIELD_W = 6;
  localparam logic [7:0] HDR_BYTE = 8'hAB;
  localparam logic [FIELD_W-1:0] PARK_VALUE = 6'h37;

  typedef enum logic [2:0] {
    OP_SAMPLE = 3'd0,
    OP_END    = 3'd1,
    OP_DIR    = 3'd2,
    OP_OUT    = 3'd3,
    OP_WAIT   = 3'd4
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [FIELD_W-1:0] arg;
  } instr_t;

  typedef enum logic [1:0] {
    PK_IDLE  = 2'd0,
    PK_RUN   = 2'd1,
    PK_DRAIN = 2'd2
  } pk_state_e;

  function automatic instr_t decode_instr(input logic [7:0] b);
    instr_t r;
    r.arg = b[FIELD_W-1:0];
    unique case (b[7:6])
      2'b10:   r.op = OP_OUT;
      2'b01:   r.op = OP_DIR;
      2'b11:   r.op = OP_WAIT;
      default: r.op = b[5] ? OP_END : OP_SAMPLE;
    endcase
    return r;
  endfunction

  // Cycles an accepted instruction keeps the interpreter occupied.
  function automatic int unsigned occupancy(input op_e op,
                                            input logic [FIELD_W-1:0] arg,
                                            input int unsigned per_us,
                                            input int unsigned step);
    int unsigned n;
    case (op)
      OP_OUT:  n = step;
      OP_WAIT: n = 32'(arg) * per_us;
      default: n = 1;
    endcase
    return n;
  endfunction

  function automatic int unsigned max_occupancy(input int unsigned per_us,
                                                input int unsigned step);
    int unsigned w;
    w = ((32'd1 << FIELD_W) - 1) * per_us;
    return (w > step) ? w : step;
  endfunction

endpackage

// File: rtl/pstream_decode.sv
module pstream_decode
  import pstream_pkg::*;
(
  input  logic [7:0] byte_in,
  output instr_t     instr
);
  always_comb instr = decode_instr(byte_in);
endmodule

// File: rtl/pstream_timer.sv
module pstream_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/pstream_pins.sv
module pstream_pins
  import pstream_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_out,
  input  logic               ld_oe,
  input  logic               smp,
  input  logic [FIELD_W-1:0] arg,
  input  logic [IN_W-1:0]    pin_in,
  output logic [FIELD_W-1:0] pin_out,
  output logic [FIELD_W-1:0] pin_oe,
  output logic               rsp_valid,
  output logic [IN_W-1:0]    rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out   <= PARK_VALUE;
      pin_oe    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (ld_out) pin_out <= arg;
      if (ld_oe)  pin_oe  <= arg;
      rsp_valid <= smp;
      if (smp) rsp_data <= pin_in;
    end
  end
endmodule

// File: rtl/pstream_interp.sv
module pstream_interp
  import pstream_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int STEP_CYCLES = 75,
  parameter int IN_W        = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  input  logic [7:0]         up_data,
  input  logic               up_last,
  output logic               up_ready,
  input  logic [IN_W-1:0]    pin_in,
  output logic [FIELD_W-1:0] pin_out,
  output logic [FIELD_W-1:0] pin_oe,
  output logic               rsp_valid,
  output logic [IN_W-1:0]    rsp_data
);
  localparam int unsigned MAX_OCC = max_occupancy(CLK_PER_US, STEP_CYCLES);
  localparam int WAIT_W = $clog2(MAX_OCC + 1);

  pk_state_e state, state_nxt;
  instr_t    instr;
  logic      busy;
  logic      accept;
  logic      exec;
  int unsigned occ;
  logic [WAIT_W-1:0] hold_val;

  // Named events for the checker
  logic               ev_load_out, ev_load_oe, ev_sample, ev_wait;
  logic [FIELD_W-1:0] ev_arg;

  pstream_decode u_dec (
    .byte_in (up_data),
    .instr   (instr)
  );

  assign up_ready = ~busy;
  assign accept   = up_valid & up_ready;
  assign exec     = accept & (state == PK_RUN);

  assign ev_load_out = exec & (instr.op == OP_OUT);
  assign ev_load_oe  = exec & (instr.op == OP_DIR);
  assign ev_sample   = exec & (instr.op == OP_SAMPLE);
  assign ev_wait     = exec & (instr.op == OP_WAIT);
  assign ev_arg      = instr.arg;

  always_comb begin
    state_nxt = state;
    if (accept) begin
      unique case (state)
        PK_IDLE: begin
          if (up_last)                    state_nxt = PK_IDLE;
          else if (up_data == HDR_BYTE)   state_nxt = PK_RUN;
          else                            state_nxt = PK_DRAIN;
        end
        PK_RUN: begin
          if (up_last)                    state_nxt = PK_IDLE;
          else if (instr.op == OP_END)    state_nxt = PK_DRAIN;
          else                            state_nxt = PK_RUN;
        end
        default: begin
          if (up_last)                    state_nxt = PK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PK_IDLE;
    else        state <= state_nxt;
  end

  always_comb begin
    occ      = occupancy(instr.op, instr.arg, CLK_PER_US, STEP_CYCLES);
    hold_val = (occ == 0) ? '0 : WAIT_W'(occ - 1);
  end

  pstream_timer #(.CNT_W(WAIT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (exec),
    .load_val (hold_val),
    .busy     (busy)
  );

  pstream_pins #(.IN_W(IN_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_out    (ev_load_out),
    .ld_oe     (ev_load_oe),
    .smp       (ev_sample),
    .arg       (instr.arg),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/pstream_interp_chk.sv
module pstream_interp_chk
  import pstream_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int STEP_CYCLES = 75,
  parameter int IN_W        = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_ready,
  input logic [IN_W-1:0]    pin_in,
  input logic [FIELD_W-1:0] pin_out,
  input logic [FIELD_W-1:0] pin_oe,
  input logic               rsp_valid,
  input logic [IN_W-1:0]    rsp_data,
  input logic               ev_load_out,
  input logic               ev_load_oe,
  input logic               ev_sample,
  input logic               ev_wait,
  input logic [FIELD_W-1:0] ev_arg
);
  a_r3_out_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_out |=> (pin_out == $past(ev_arg)));

  a_r3_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load_out |=> $stable(pin_out));

  a_r4_oe_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_oe |=> (pin_oe == $past(ev_arg)));

  a_r4_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load_oe |=> $stable(pin_oe));

  a_r7_rsp_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |=> (rsp_valid && rsp_data == $past(pin_in)));

  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sample |=> !rsp_valid);

  a_r6_zero_wait_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wait && ev_arg == '0) |=> up_ready);

  generate
    if (STEP_CYCLES > 1) begin : g_step
      a_r5_step_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        ev_load_out |=> !up_ready);
    end
    if (CLK_PER_US > 1) begin : g_us
      a_r6_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wait && ev_arg != '0) |=> !up_ready);
    end
  endgenerate
endmodule

bind pstream_interp pstream_interp_chk #(
  .CLK_PER_US  (CLK_PER_US),
  .STEP_CYCLES (STEP_CYCLES),
  .IN_W        (IN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_ready    (up_ready),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .ev_load_out (ev_load_out),
  .ev_load_oe  (ev_load_oe),
  .ev_sample   (ev_sample),
  .ev_wait     (ev_wait),
  .ev_arg      (ev_arg)
);

// File: tb/pstream_interp_test.sv
module pstream_interp_test;
  localparam int PER_US = 100;
  localparam int STEP   = 75;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_valid = 1'b0;
  logic [7:0] up_data = 8'h00;
  logic       up_last = 1'b0;
  logic       up_ready;
  logic [7:0] pin_in = 8'h00;
  logic [5:0] pin_out, pin_oe;
  logic       rsp_valid;
  logic [7:0] rsp_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  logic [7:0] exp_data_q[$];
  int         exp_cyc_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pstream_interp #(.CLK_PER_US(PER_US), .STEP_CYCLES(STEP), .IN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
    .up_last(up_last), .up_ready(up_ready), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: offers one byte, pushes the expected response when the bench
  // model says the byte is a sample inside an open packet, and measures
  // the stall that follows acceptance.
  task automatic send(input logic [7:0] b, input bit last, input bit exp_rsp,
                      output int stall);
    @(negedge clk);
    up_valid = 1'b1; up_data = b; up_last = last;
    forever begin
      if (up_ready) begin
        if (exp_rsp) begin
          exp_data_q.push_back(pin_in);
          exp_cyc_q.push_back(cyc + 1);
        end
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    up_valid = 1'b0; up_last = 1'b0;
    stall = 0;
    while (!up_ready) begin
      stall++;
      @(negedge clk);
    end
  endtask

  // Monitor: scoreboard for the response stream
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_data_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R7/R8 unexpected response: actual 0x%0h expected none", rsp_data);
      end else begin
        check("R7 response data", rsp_data, exp_data_q.pop_front());
        check("R7 response cycle", cyc, exp_cyc_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pin_out reset", pin_out, 6'h37);
    check("R1 pin_oe reset", pin_oe, 6'h00);
    check("R1 ready reset", up_ready, 1);
    check("R1 rsp_valid reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // Main packet
    send(8'hAB, 0, 0, st);
    check("R9 header no stall", st, 0);
    send(8'h40 | 8'h3F, 0, 0, st);
    check("R4 enable all", pin_oe, 6'h3F);
    send(8'h80 | 8'h36, 0, 0, st);
    check("R3 load 0x36", pin_out, 6'h36);
    check("R5 step stall", st, STEP - 1);
    send(8'h80 | 8'h36, 0, 0, st);
    check("R5 repeated step stall", st, STEP - 1);
    pin_in = 8'hA5;
    send(8'h00, 0, 1, st);
    check("R7 sample no stall", st, 0);
    pin_in = 8'h3C;
    send(8'h1F, 0, 1, st);
    send(8'hC0 | 8'h02, 0, 0, st);
    check("R6 wait 2us", st, 2 * PER_US - 1);
    send(8'hC0, 0, 0, st);
    check("R6 wait zero", st, 0);
    send(8'h80 | 8'h37, 1, 0, st);
    check("R3 load 0x37", pin_out, 6'h37);

    // R2 non-header packet
    send(8'h80, 0, 0, st);
    send(8'h40, 0, 0, st);
    send(8'h00, 1, 0, st);
    check("R2 out untouched", pin_out, 6'h37);
    check("R2 oe untouched", pin_oe, 6'h3F);

    // R8 end instruction
    send(8'hAB, 0, 0, st);
    send(8'h80 | 8'h15, 0, 0, st);
    send(8'h20, 0, 0, st);
    check("R8 end no stall", st, 0);
    send(8'h80 | 8'h2A, 0, 0, st);
    check("R8 ignored load no stall", st, 0);
    send(8'h00, 0, 0, st);
    send(8'h40, 1, 0, st);
    check("R8 out after end", pin_out, 6'h15);
    check("R8 oe after end", pin_oe, 6'h3F);

    // R9 last closes packet
    send(8'hAB, 0, 0, st);
    send(8'h80 | 8'h01, 1, 0, st);
    check("R9 load before last", pin_out, 6'h01);
    send(8'h80 | 8'h02, 1, 0, st);
    check("R9 headerless after close", pin_out, 6'h01);
    send(8'hAB, 1, 0, st);
    send(8'h00, 1, 0, st);
    send(8'h80 | 8'h03, 1, 0, st);
    check("R9 lone header", pin_out, 6'h01);

    // R10 load while tri-stated
    send(8'hAB, 0, 0, st);
    send(8'h40, 0, 0, st);
    check("R4 tri-state", pin_oe, 6'h00);
    send(8'h80 | 8'h0C, 0, 0, st);
    check("R10 out while tri-stated", pin_out, 6'h0C);
    pin_in = 8'h5A;
    send(8'h00, 1, 1, st);
    check("R10 oe still off", pin_oe, 6'h00);

    repeat (4) @(negedge clk);
    check("R7 all responses seen", exp_data_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule